// File: doc/BRIEF.md
# NOR Sector Erase Sequencer

This block performs a sector erase on a NOR-style bit-cell array as a staged internal algorithm rather than as one atomic write of all ones. A single erase command names a sector. The sequencer first drives every cell of that sector into the programmed state, reading '0'. It then applies sector-wide erase pulses and verifies them. Last, it repairs any over-erased cells with soft-program pulses. Only when all three stages have finished does it report completion. Because the first stage is always run, every cell in the sector passes through a full program-erase cycle, whatever data it held before.

The array side is a plain strobe port. The array address is `{sector, word}`, and read data and the over-erase flag are returned combinationally for the address driven in that cycle. Each of the four strobes (read, program pulse, erase pulse, soft-program pulse) acts at the clock edge that ends the cycle in which it is high. The command side uses plain control pins with no back-pressure. While `busy` is low, a `cmd_valid` pulse is taken. While `busy` is high, commands are dropped. No data stream crosses the boundary, so there is no valid/ready pair.

Top module: `nor_erase_seq`

## Requirements
- R1: `cmd_valid` sampled high while `busy` is low starts an operation, and `busy` is high in the following cycle. `cmd_valid` while `busy` is high has no effect on the running operation and starts no other operation.
- R2: In the preprogram stage each word of the sector is read in ascending word order. A word that reads nonzero receives a program pulse whose mask is exactly the set of bits that read '1' (mask bit = 1 means program that bit). A word that reads zero receives no pulse.
- R3: If a word still reads nonzero after PGM_TRIES program pulses, the operation ends with `done_ok` = 0 and no erase pulse is issued.
- R4: No erase pulse is issued until every word of the sector has read all zeros. The erase pulse covers the sector held in the upper address bits.
- R5: After each erase pulse, every word of the sector is read. A word that does not read all ones triggers another erase pulse. The total number of erase pulses never exceeds ERASE_MAX. If that limit is reached without a clean verify, the operation ends with `done_ok` = 0.
- R6: In the recovery stage each word whose over-erase flag is 1 receives soft-program pulses until the flag clears. If the flag is still set after SOFT_TRIES pulses, the operation ends with `done_ok` = 0. Clean words get no pulse.
- R7: `done` is high for exactly one cycle per accepted command, `done_ok` = 1 in that cycle when all stages succeeded, and `busy` is low in the following cycle.
- R8: At most one of the four array strobes is high in any cycle.
- R9: While busy, the sector bits of `arr_addr` equal the accepted command's sector, so no other sector is read or altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Erase request, taken when not busy |
| cmd_sector | input | SECT_W | Sector to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Pass status, valid with done |
| arr_addr | output | SECT_W+WORD_W | Array address {sector, word} |
| arr_rd | output | 1 | Read strobe |
| arr_rdata | input | DATA_W | Word read data for arr_addr |
| arr_overerase | input | 1 | Over-erase flag for the word at arr_addr |
| arr_pgm | output | 1 | Program pulse strobe |
| arr_pgm_mask | output | DATA_W | Bits to program during arr_pgm |
| arr_erase | output | 1 | Sector erase pulse strobe |
| arr_soft | output | 1 | Soft-program pulse strobe |

## Verification
Every sector is erased from four contents: all ones, all zeros, an arithmetic byte pattern and a walking single bit. The all-zeros case separates "pulse only words holding a 1" from "pulse every word". The walking bit shows that the program mask follows the data read back. Erase-resistant arrays that need one to three extra pulses, and a resistance equal to the limit, separate the last allowed pulse from one too many. Over-erase patterns show that soft pulses reach only flagged words. Stuck program, erase and soft-program cells distinguish each stage's failure exit from a silent pass. Foreign commands issued mid-operation must leave the other sectors' contents untouched.

// File: rtl/nes_pkg.sv
package nes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PP_RD,
    ST_PP_PGM,
    ST_ER_PULSE,
    ST_ER_RD,
    ST_RC_RD,
    ST_RC_SOFT,
    ST_DONE
  } nes_state_e;
endpackage

// File: rtl/nes_try_ctr.sv
module nes_try_ctr #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_lim
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !at_lim) cnt <= cnt + 1'b1;
  end

  assign at_lim = (cnt == CW'(LIMIT));

  AST_CTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT)); // R5
endmodule

// File: rtl/nes_word_idx.sv
module nes_word_idx #(
  parameter int WORDS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       adv,
  output logic [$clog2(WORDS)-1:0]   idx,
  output logic                       last
);
  localparam int WW = $clog2(WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (adv)  idx <= idx + 1'b1;
  end

  assign last = (idx == WW'(WORDS - 1));

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (idx == $past(idx) + 1'b1)); // R2
endmodule

// File: rtl/nes_word_eval.sv
module nes_word_eval #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic              all_zero,
  output logic              all_one
);
  assign all_zero = (data == '0);
  assign all_one  = (data == '1);
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int SECTORS    = 4,
  parameter int WORDS      = 8,
  parameter int DATA_W     = 8,
  parameter int PGM_TRIES  = 3,
  parameter int ERASE_MAX  = 4,
  parameter int SOFT_TRIES = 2,
  localparam int SECT_W    = $clog2(SECTORS),
  localparam int WORD_W    = $clog2(WORDS),
  localparam int ADDR_W    = SECT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [SECT_W-1:0] cmd_sector,
  output logic              busy,
  output logic              done,
  output logic              done_ok,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_rd,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              arr_overerase,
  output logic              arr_pgm,
  output logic [DATA_W-1:0] arr_pgm_mask,
  output logic              arr_erase,
  output logic              arr_soft
);
  import nes_pkg::*;

  nes_state_e state, nxt;
  logic [SECT_W-1:0] sect_q;
  logic [DATA_W-1:0] mask_q;
  logic              ok_q;
  logic [WORD_W-1:0] widx;
  logic              wlast, rd_zero, rd_one;
  logic              idx_clr, idx_adv;
  logic              pt_clr, pt_inc, pt_lim;
  logic              er_clr, er_inc, er_lim;
  logic              st_clr, st_inc, st_lim;
  logic              set_pass, set_fail;

  nes_word_idx #(.WORDS(WORDS)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .adv(idx_adv),
    .idx(widx), .last(wlast));

  nes_word_eval #(.DATA_W(DATA_W)) u_eval (
    .data(arr_rdata), .all_zero(rd_zero), .all_one(rd_one));

  nes_try_ctr #(.LIMIT(PGM_TRIES)) u_pgm_try (
    .clk(clk), .rst_n(rst_n), .clr(pt_clr), .inc(pt_inc), .at_lim(pt_lim));

  nes_try_ctr #(.LIMIT(ERASE_MAX)) u_er_cnt (
    .clk(clk), .rst_n(rst_n), .clr(er_clr), .inc(er_inc), .at_lim(er_lim));

  nes_try_ctr #(.LIMIT(SOFT_TRIES)) u_soft_try (
    .clk(clk), .rst_n(rst_n), .clr(st_clr), .inc(st_inc), .at_lim(st_lim));

  always_comb begin
    nxt      = state;
    idx_clr  = 1'b0;
    idx_adv  = 1'b0;
    pt_clr   = 1'b0;
    pt_inc   = 1'b0;
    er_clr   = 1'b0;
    er_inc   = 1'b0;
    st_clr   = 1'b0;
    st_inc   = 1'b0;
    set_pass = 1'b0;
    set_fail = 1'b0;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        nxt     = ST_PP_RD;
        idx_clr = 1'b1;
        pt_clr  = 1'b1;
        er_clr  = 1'b1;
      end
      ST_PP_RD: begin
        if (!rd_zero) begin
          if (pt_lim) begin
            set_fail = 1'b1;
            nxt      = ST_DONE;
          end else begin
            nxt = ST_PP_PGM;
          end
        end else begin
          pt_clr = 1'b1;
          if (wlast) begin
            idx_clr = 1'b1;
            nxt     = ST_ER_PULSE;
          end else begin
            idx_adv = 1'b1;
          end
        end
      end
      ST_PP_PGM: begin
        pt_inc = 1'b1;
        nxt    = ST_PP_RD;
      end
      ST_ER_PULSE: begin
        er_inc  = 1'b1;
        idx_clr = 1'b1;
        nxt     = ST_ER_RD;
      end
      ST_ER_RD: begin
        if (!rd_one) begin
          if (er_lim) begin
            set_fail = 1'b1;
            nxt      = ST_DONE;
          end else begin
            nxt = ST_ER_PULSE;
          end
        end else if (wlast) begin
          idx_clr = 1'b1;
          st_clr  = 1'b1;
          nxt     = ST_RC_RD;
        end else begin
          idx_adv = 1'b1;
        end
      end
      ST_RC_RD: begin
        if (arr_overerase) begin
          if (st_lim) begin
            set_fail = 1'b1;
            nxt      = ST_DONE;
          end else begin
            nxt = ST_RC_SOFT;
          end
        end else begin
          st_clr = 1'b1;
          if (wlast) begin
            set_pass = 1'b1;
            nxt      = ST_DONE;
          end else begin
            idx_adv = 1'b1;
          end
        end
      end
      ST_RC_SOFT: begin
        st_inc = 1'b1;
        nxt    = ST_RC_RD;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sect_q <= '0;
      mask_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && cmd_valid) sect_q <= cmd_sector;
      if (state == ST_PP_RD)             mask_q <= arr_rdata;
      if (set_pass)                      ok_q   <= 1'b1;
      else if (set_fail)                 ok_q   <= 1'b0;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_DONE);
  assign done_ok      = done && ok_q;
  assign arr_addr     = {sect_q, widx};
  assign arr_rd       = (state == ST_PP_RD) || (state == ST_ER_RD) || (state == ST_RC_RD);
  assign arr_pgm      = (state == ST_PP_PGM);
  assign arr_pgm_mask = arr_pgm ? mask_q : '0;
  assign arr_erase    = (state == ST_ER_PULSE);
  assign arr_soft     = (state == ST_RC_SOFT);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_rd, arr_pgm, arr_erase, arr_soft})); // R8
  AST_PGM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    arr_pgm |-> (arr_pgm_mask != '0) && ((arr_pgm_mask & ~$past(arr_rdata)) == '0)); // R2
  AST_ERASE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> $past(arr_rd) && ($past(arr_rdata) == '0 || $past(arr_rdata) != '1)); // R4
  AST_SECTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (arr_addr[ADDR_W-1:WORD_W] == $past(arr_addr[ADDR_W-1:WORD_W]))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy); // R1
endmodule

// File: tb/tb_nor_erase_seq.sv
module tb_nor_erase_seq;
  localparam int SECTORS = 4, WORDS = 8, DATA_W = 8;
  localparam int PGM_TRIES = 3, ERASE_MAX = 4, SOFT_TRIES = 2;
  localparam int NADDR = SECTORS * WORDS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_sector = '0;
  logic busy, done, done_ok, arr_rd, arr_pgm, arr_erase, arr_soft, arr_overerase;
  logic [4:0] arr_addr;
  logic [7:0] arr_rdata, arr_pgm_mask;

  logic [7:0] mem [NADDR];
  logic       oe  [NADDR];
  logic [7:0] init_img [NADDR];
  int n_pgm, n_er, n_soft, mask_err, pp_err, resist_left, stuck_pgm, stuck_oe;
  int cur_sec, tests, fails, cycles;
  logic [7:0] oe_pat;

  always #4 clk = ~clk;

  nor_erase_seq #(.SECTORS(SECTORS), .WORDS(WORDS), .DATA_W(DATA_W),
    .PGM_TRIES(PGM_TRIES), .ERASE_MAX(ERASE_MAX), .SOFT_TRIES(SOFT_TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sector(cmd_sector),
    .busy(busy), .done(done), .done_ok(done_ok), .arr_addr(arr_addr),
    .arr_rd(arr_rd), .arr_rdata(arr_rdata), .arr_overerase(arr_overerase),
    .arr_pgm(arr_pgm), .arr_pgm_mask(arr_pgm_mask), .arr_erase(arr_erase),
    .arr_soft(arr_soft));

  assign arr_rdata     = mem[arr_addr];
  assign arr_overerase = oe[arr_addr];

  // behavioural cell array
  always @(posedge clk) begin
    cycles++;
    if (arr_pgm) begin
      n_pgm++;
      if (arr_pgm_mask != mem[arr_addr]) mask_err++;
      if (int'(arr_addr) != cur_sec * WORDS + stuck_pgm)
        mem[arr_addr] <= mem[arr_addr] & ~arr_pgm_mask;
    end
    if (arr_erase) begin
      if (n_er == 0)
        for (int w = 0; w < WORDS; w++)
          if (mem[int'(arr_addr[4:3]) * WORDS + w] != 8'h00) pp_err++;
      n_er++;
      for (int w = 0; w < WORDS; w++) begin
        mem[int'(arr_addr[4:3]) * WORDS + w] <= (resist_left > 0 && w == 0) ? 8'h7F : 8'hFF;
        oe[int'(arr_addr[4:3]) * WORDS + w]  <= (resist_left > 0) ? 1'b0 : oe_pat[w];
      end
      if (resist_left > 0) resist_left--;
    end
    if (arr_soft) begin
      n_soft++;
      if (int'(arr_addr) != cur_sec * WORDS + stuck_oe) oe[arr_addr] <= 1'b0;
    end
  end

  always @(posedge clk) if (cycles > 190000) begin
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int kind, int a);
    case (kind)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'((a * 37 + 11) % 256);
      default: return 8'(1 << (a % 8));
    endcase
  endfunction

  task automatic run_case(int sec, int kind, int spg, int resist, logic [7:0] opat, int soe);
    int e_pgm, e_er, e_soft, dn, seen;
    bit e_ok;
    cur_sec = sec; stuck_pgm = spg; stuck_oe = soe; resist_left = resist; oe_pat = opat;
    n_pgm = 0; n_er = 0; n_soft = 0; mask_err = 0; pp_err = 0;
    for (int a = 0; a < NADDR; a++) begin
      mem[a] = pat(kind, a); init_img[a] = mem[a]; oe[a] = 1'b0;
    end
    // expected values from the requirements
    e_ok = 1; e_pgm = 0; e_er = 0; e_soft = 0;
    for (int w = 0; w < WORDS; w++)
      if (pat(kind, sec * WORDS + w) != 0) begin
        if (w == spg) begin e_pgm += PGM_TRIES; e_ok = 0; break; end
        e_pgm += 1;
      end
    if (e_ok) begin
      if (resist >= ERASE_MAX) begin e_er = ERASE_MAX; e_ok = 0; end
      else e_er = resist + 1;
    end
    if (e_ok)
      for (int w = 0; w < WORDS; w++)
        if (opat[w]) begin
          if (w == soe) begin e_soft += SOFT_TRIES; e_ok = 0; break; end
          e_soft += 1;
        end
    @(negedge clk);
    cmd_sector = 2'(sec); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R1 busy after command", int'(busy), 1);
    repeat (3) @(negedge clk);
    cmd_sector = 2'(sec + 1); cmd_valid = 1'b1;  // foreign command while busy (R1)
    @(negedge clk);
    cmd_valid = 1'b0;
    seen = 0;
    for (int t = 0; t < 3000 && !seen; t++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen == 1, "R7 done seen", seen, 1);
    chk(done_ok == e_ok, "R7 done_ok status", int'(done_ok), int'(e_ok));
    @(negedge clk);
    chk(!done && !busy, "R7 single-cycle done, busy low", int'({done, busy}), 0);
    dn = 0;
    repeat (6) begin @(negedge clk); if (done || busy) dn++; end
    chk(dn == 0, "R1 ignored command starts nothing", dn, 0);
    chk(n_pgm == e_pgm, "R2/R3 program pulses", n_pgm, e_pgm);
    chk(mask_err == 0, "R2 program mask equals ones read", mask_err, 0);
    chk(pp_err == 0, "R4 sector zero before erase", pp_err, 0);
    chk(n_er == e_er, "R5 erase pulses", n_er, e_er);
    chk(n_soft == e_soft, "R6 soft pulses", n_soft, e_soft);
    if (e_ok) begin
      int bad = 0;
      for (int w = 0; w < WORDS; w++) if (mem[sec * WORDS + w] != 8'hFF || oe[sec * WORDS + w]) bad++;
      chk(bad == 0, "R5/R6 sector erased and clean", bad, 0);
    end
    begin
      int other = 0;
      for (int a = 0; a < NADDR; a++)
        if (a / WORDS != sec && mem[a] != init_img[a]) other++;
      chk(other == 0, "R9 other sectors untouched", other, 0);
    end
  endtask

  // strobe exclusivity watched at the ports
  always @(negedge clk) if (rst_n && ($countones({arr_rd, arr_pgm, arr_erase, arr_soft}) > 1))
    chk(0, "R8 strobe overlap", $countones({arr_rd, arr_pgm, arr_erase, arr_soft}), 1);

  initial begin
    tests = 0; fails = 0; cycles = 0; cur_sec = 0; stuck_pgm = -1; stuck_oe = -1;
    resist_left = 0; oe_pat = '0; n_pgm = 0; n_er = 0; n_soft = 0; mask_err = 0; pp_err = 0;
    for (int a = 0; a < NADDR; a++) begin mem[a] = '0; oe[a] = 1'b0; init_img[a] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !arr_rd && !arr_pgm && !arr_erase && !arr_soft,
        "R7 reset state idle", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep: every sector, every data pattern, varied resistance and over-erase patterns
    for (int s = 0; s < SECTORS; s++)
      for (int k = 0; k < 4; k++)
        run_case(s, k, -1, (s + k) % 3, 8'((s * 53 + k * 29) % 256), -1);
    run_case(1, 2, -1, ERASE_MAX - 1, 8'hA5, -1);  // last allowed erase pulse (R5)
    run_case(2, 0, 5, 0, 8'h00, -1);               // stuck program cell (R3)
    run_case(0, 1, 0, 0, 8'h00, -1);               // stuck word but already zero (R2)
    run_case(3, 3, -1, ERASE_MAX, 8'h00, -1);      // erase never verifies (R5)
    run_case(1, 0, -1, 0, 8'h18, 4);               // stuck over-erased cell (R6)
    run_case(2, 2, -1, 0, 8'hFF, -1);              // every word over-erased (R6)
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule